// File: doc/BRIEF.md
# Descriptor List Walking DMA Engine

This block walks a list of four-word descriptors kept in system memory and turns every non-empty buffer it finds into a transfer command for an external data mover. It reads each descriptor one word at a time through a simple word-wide read port. It then checks that the engine, not the host, owns the entry, and issues address and byte-count commands over a valid/ready handshake. Finally it writes the first word back with the ownership flag cleared, which hands the entry back to software.

A flag in each descriptor selects one of two layouts. In the chained layout the fourth word points to the next descriptor. In the dual-buffer layout the fourth word is a second buffer address. Dual-buffer entries sit back to back in memory, and an end-of-ring flag wraps the walk back to the list base. When the engine meets an entry it does not own, it parks with a descriptor-unavailable indication until software pulses a poll input. A completion pulse on the transmit or the receive line marks the end of each packet unless that descriptor suppresses it. The written-back first word carries a summary of the card error flags.

Top module: `desc_walker`

## Requirements
- R1: After a `start` pulse the engine reads the four words of the first descriptor at `list_base`, `+4`, `+8` and `+12`, in that order, with address bits 1:0 forced to zero.
- R2: If word 0 bit 31 (the ownership flag) of a fetched descriptor is 0, the engine makes no further read, command or write, and `unavail` is 1. On a `poll` pulse it leaves that state in the next cycle and fetches word 0 of the same descriptor again.
- R3: When word 0 bit 4 (chain flag) is 1, the engine issues one command with address word 2 (bits 1:0 cleared) and byte count word 1 bits 12:0. It ignores word 1 bits 25:13 and fetches the next descriptor from word 3 with bits 1:0 cleared.
- R4: When word 0 bit 4 is 0, the engine issues a command for buffer 1 and then one for buffer 2. Buffer 2 uses address word 3 (bits 1:0 cleared) and byte count word 1 bits 25:13. The next descriptor is at the current address plus 16, or at `list_base` when word 0 bit 5 (end of ring) is 1.
- R5: A buffer whose size field is zero produces no command, and the engine moves on to the next buffer or to the write-back.
- R6: Once the commands are accepted, the engine writes one word to the descriptor's own address. That word has bit 31 = 0, bit 30 = OR of the seven `err_flags` bits, and bits 29:0 as fetched.
- R7: Consider a descriptor with word 0 bit 2 (last) = 1 and bit 1 (interrupt disable) = 0. In the cycle after its write-back is acknowledged, the engine pulses `rx_int` for one cycle if `rx_dir` = 1, or `tx_int` if `rx_dir` = 0. No pulse follows any other descriptor.
- R8: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_addr` and `cmd_bytes` hold their values.
- R9: During and right after reset, `rd_en`, `cmd_valid`, `wr_en`, `tx_int`, `rx_int` and `unavail` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin walking at `list_base` |
| poll | input | 1 | Resume after a descriptor-unavailable stop |
| list_base | input | AW | Base address of the descriptor list |
| rx_dir | input | 1 | 1: receive direction, 0: transmit |
| err_flags | input | 7 | Card error flags folded into the summary bit |
| rd_en | output | 1 | Descriptor word read request, held until `rd_valid` |
| rd_addr | output | AW | Read word address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_addr | output | AW | Buffer address |
| cmd_bytes | output | 13 | Buffer byte count |
| cmd_ready | input | 1 | Data mover accepts the command |
| wr_en | output | 1 | Write-back request, held until `wr_ack` |
| wr_addr | output | AW | Write-back address |
| wr_data | output | 32 | Write-back word |
| wr_ack | input | 1 | Write-back accepted |
| tx_int | output | 1 | Transmit completion pulse |
| rx_int | output | 1 | Receive completion pulse |
| unavail | output | 1 | Stopped on a host-owned descriptor |

## Verification
Every memory and command exchange is a handshake of unknown length, so the bench does not count cycles for whole-descriptor results. It lets the walk run until `unavail` rises at the next unowned entry. Only then does it compare the logged commands, the write-back word and the last fetch address, all of which must be complete by then. The results that are tied to an exact cycle are checked at the falling edge of that cycle. These are the completion pulse, one cycle after the write-back acknowledge, and the exit from the stopped state, in the cycle after `poll` with a read of the same descriptor. The command hold under a stalled ready is sampled several cycles into the stall.

// File: rtl/desc_walker.sv
module desc_walker #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          poll,
  input  logic [AW-1:0] list_base,
  input  logic          rx_dir,
  input  logic [6:0]    err_flags,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [31:0]   rd_data,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic [12:0]   cmd_bytes,
  input  logic          cmd_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  input  logic          wr_ack,
  output logic          tx_int,
  output logic          rx_int,
  output logic          unavail
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_BUF1, S_BUF2, S_WB, S_HALT} st_t;

  st_t           st;
  logic [AW-1:0] cur;
  logic [1:0]    idx;
  logic [31:0]   words [4];
  logic          tx_q, rx_q;

  wire          chain    = words[0][4];
  wire          ring_end = words[0][5];
  wire          last     = words[0][2];
  wire          no_irq   = words[0][1];
  wire [12:0]   bs1      = words[1][12:0];
  wire [12:0]   bs2      = words[1][25:13];
  wire [AW-1:0] base_al  = {list_base[AW-1:2], 2'b00};
  wire [AW-1:0] buf1     = {words[2][AW-1:2], 2'b00};
  wire [AW-1:0] link     = {words[3][AW-1:2], 2'b00};
  wire          use1     = bs1 != '0;
  wire          use2     = !chain && bs2 != '0;

  logic [AW-1:0] nxt;
  always_comb begin
    if (chain)         nxt = link;
    else if (ring_end) nxt = base_al;
    else               nxt = cur + AW'(16);
  end

  logic unused_bits;
  assign unused_bits = ^{words[1][31:26], words[2][1:0], words[3][1:0], list_base[1:0]};

  assign rd_en     = st == S_FETCH;
  assign rd_addr   = cur + AW'({idx, 2'b00});
  assign cmd_valid = (st == S_BUF1 && use1) || (st == S_BUF2 && use2);
  assign cmd_addr  = st == S_BUF2 ? link : buf1;
  assign cmd_bytes = st == S_BUF2 ? bs2 : bs1;
  assign wr_en     = st == S_WB;
  assign wr_addr   = cur;
  assign wr_data   = {1'b0, |err_flags, words[0][29:0]};
  assign tx_int    = tx_q;
  assign rx_int    = rx_q;
  assign unavail   = st == S_HALT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cur  <= '0;
      idx  <= '0;
      tx_q <= 1'b0;
      rx_q <= 1'b0;
      for (int i = 0; i < 4; i++) words[i] <= '0;
    end else begin
      tx_q <= 1'b0;
      rx_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cur <= base_al;
          idx <= '0;
          st  <= S_FETCH;
        end
        S_FETCH: if (rd_valid) begin
          words[idx] <= rd_data;
          if (idx == 2'd0 && !rd_data[31]) st <= S_HALT;
          else begin
            idx <= idx + 2'd1;
            if (idx == 2'd3) st <= S_BUF1;
          end
        end
        S_BUF1: if (!use1 || cmd_ready) st <= chain ? S_WB : S_BUF2;
        S_BUF2: if (!use2 || cmd_ready) st <= S_WB;
        S_WB: if (wr_ack) begin
          cur <= nxt;
          idx <= '0;
          st  <= S_FETCH;
          if (last && !no_irq) begin
            tx_q <= !rx_dir;
            rx_q <= rx_dir;
          end
        end
        S_HALT: if (poll) begin
          idx <= '0;
          st  <= S_FETCH;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module desc_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          poll,
  input logic          rd_en,
  input logic          cmd_valid,
  input logic [AW-1:0] cmd_addr,
  input logic [12:0]   cmd_bytes,
  input logic          cmd_ready,
  input logic          wr_en,
  input logic          wr_ack,
  input logic          tx_int,
  input logic          rx_int,
  input logic          unavail
);
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_bytes)); // R8
  AST_NO_EMPTY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_bytes != '0); // R5
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    unavail |-> !rd_en && !cmd_valid && !wr_en); // R2
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    unavail && !poll |=> unavail); // R2
  AST_POLL_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    unavail && poll |=> !unavail && rd_en); // R2
  AST_WB_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !cmd_valid && !rd_en); // R6
  AST_INT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_int, rx_int})); // R7
  AST_INT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_int || rx_int) |-> $past(wr_en && wr_ack)); // R7
endmodule

bind desc_walker desc_walker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .poll(poll), .rd_en(rd_en), .cmd_valid(cmd_valid),
  .cmd_addr(cmd_addr), .cmd_bytes(cmd_bytes), .cmd_ready(cmd_ready), .wr_en(wr_en),
  .wr_ack(wr_ack), .tx_int(tx_int), .rx_int(rx_int), .unavail(unavail)
);

// File: tb/tb_desc_walker.sv
`timescale 1ns/1ps
module tb_desc_walker;
  logic clk = 0, rst_n = 0, start = 0, poll = 0, rx_dir = 0;
  logic [31:0] list_base = 0;
  logic [6:0]  err_flags = 0;
  logic rd_en, rd_valid = 0, cmd_valid, cmd_ready = 0, wr_en, wr_ack = 0;
  logic [31:0] rd_addr, rd_data = 0, cmd_addr, wr_addr, wr_data;
  logic [12:0] cmd_bytes;
  logic tx_int, rx_int, unavail;

  always #10 clk = ~clk;

  desc_walker dut (.*);

  int checks = 0, errors = 0;
  logic [31:0] mem [64];
  int n_rd, n_cmd, n_wr, n_tx, n_rx, cyc = 0;
  logic [31:0] rd_hist [8];
  logic [31:0] last_rd, ca [4], wb_addr, wb_data;
  logic [12:0] cb [4];
  logic rdy_block = 0;

  always @(posedge clk) begin
    cyc++;
    rd_valid <= rd_en && !rd_valid;
    rd_data  <= mem[rd_addr[7:2]];
    wr_ack   <= wr_en && !wr_ack;
    cmd_ready <= !rdy_block && (cyc % 3 != 0);
    if (rd_en && rd_valid) begin
      if (n_rd < 8) rd_hist[n_rd] = rd_addr;
      last_rd = rd_addr;
      n_rd++;
    end
    if (cmd_valid && cmd_ready) begin
      if (n_cmd < 4) begin ca[n_cmd] = cmd_addr; cb[n_cmd] = cmd_bytes; end
      n_cmd++;
    end
    if (wr_en && wr_ack) begin
      mem[wr_addr[7:2]] = wr_data;
      wb_addr = wr_addr; wb_data = wr_data;
      n_wr++;
    end
    if (tx_int) n_tx++;
    if (rx_int) n_rx++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; start = 0; poll = 0; rdy_block = 0;
    for (int i = 0; i < 64; i++) mem[i] = 0;
    n_rd = 0; n_cmd = 0; n_wr = 0; n_tx = 0; n_rx = 0;
    last_rd = 0; wb_addr = 0; wb_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic wait_halt();
    int k = 0;
    @(negedge clk);
    while (!unavail && k < 3000) begin @(negedge clk); k++; end
    chk(unavail, "R2 halt reached", 64'(unavail), 1);
  endtask

  typedef struct packed {
    logic [31:0] w0, w1, w2, w3;
    logic [6:0]  err;
    logic        rx;
    logic [1:0]  n;
    logic [31:0] a0;
    logic [12:0] b0;
    logic [31:0] a1;
    logic [12:0] b1;
    logic [31:0] nx;
    logic        ip;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{32'h8000001C, 32'h00000040, 32'h10000003, 32'h00000082, 7'h00, 1'b0, 2'd1, 32'h10000000, 13'h040, 32'h0,        13'h0,  32'h80, 1'b1},
    '{32'h8000000C, 32'h00040010, 32'h20000000, 32'h30000001, 7'h00, 1'b1, 2'd2, 32'h20000000, 13'h010, 32'h30000000, 13'h20, 32'h50, 1'b1},
    '{32'h80000020, 32'h00008008, 32'h40000004, 32'h50000008, 7'h00, 1'b0, 2'd2, 32'h40000004, 13'h008, 32'h50000008, 13'h04, 32'h40, 1'b0},
    '{32'h80000004, 32'h00020000, 32'h0F000000, 32'h60000000, 7'h00, 1'b0, 2'd1, 32'h60000000, 13'h010, 32'h0,        13'h0,  32'h50, 1'b1},
    '{32'h80000006, 32'h00000100, 32'h70000000, 32'h0F000000, 7'h00, 1'b0, 2'd1, 32'h70000000, 13'h100, 32'h0,        13'h0,  32'h50, 1'b0},
    '{32'h80000014, 32'h00040000, 32'h0F000000, 32'h000000A0, 7'h00, 1'b0, 2'd0, 32'h0,        13'h000, 32'h0,        13'h0,  32'hA0, 1'b1},
    '{32'h80000010, 32'h00040008, 32'h12345678, 32'h000000C0, 7'h10, 1'b0, 2'd1, 32'h12345678, 13'h008, 32'h0,        13'h0,  32'hC0, 1'b0}
  };

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] held_a;
    logic [31:0] exp_wb;
    do_reset();
    chk({rd_en, cmd_valid, wr_en, tx_int, rx_int, unavail} == 0, "R9 reset outputs",
        64'({rd_en, cmd_valid, wr_en, tx_int, rx_int, unavail}), 0);

    for (int i = 0; i < 7; i++) begin
      vec_t v;
      v = VEC[i];
      do_reset();
      mem[16] = v.w0; mem[17] = v.w1; mem[18] = v.w2; mem[19] = v.w3;
      list_base = 32'h40; rx_dir = v.rx; err_flags = v.err;
      pulse_start();
      wait_halt();
      chk(n_cmd == int'(v.n), "R3 R4 R5 command count", 64'(n_cmd), 64'(v.n));
      if (v.n >= 1) begin
        chk(ca[0] == v.a0, "R3 R4 buffer 1 address", 64'(ca[0]), 64'(v.a0));
        chk(cb[0] == v.b0, "R3 R4 buffer 1 bytes", 64'(cb[0]), 64'(v.b0));
      end
      if (v.n == 2) begin
        chk(ca[1] == v.a1, "R4 buffer 2 address", 64'(ca[1]), 64'(v.a1));
        chk(cb[1] == v.b1, "R4 buffer 2 bytes", 64'(cb[1]), 64'(v.b1));
      end
      exp_wb = {1'b0, |v.err, v.w0[29:0]};
      chk(n_wr == 1 && wb_addr == 32'h40, "R6 write-back address", 64'(wb_addr), 64'h40);
      chk(wb_data == exp_wb, "R6 write-back word", 64'(wb_data), 64'(exp_wb));
      chk(last_rd == v.nx, "R3 R4 next descriptor address", 64'(last_rd), 64'(v.nx));
      chk(n_tx == int'(v.ip && !v.rx) && n_rx == int'(v.ip && v.rx), "R7 completion pulses",
          64'({n_tx[7:0], n_rx[7:0]}), 64'({7'd0, v.ip && !v.rx, 7'd0, v.ip && v.rx}));
    end

    // R1: fetch order, low base bits ignored
    do_reset();
    mem[16] = 32'h80000010; mem[17] = 32'h4; mem[18] = 32'h100; mem[19] = 32'h80;
    list_base = 32'h43; rx_dir = 0; err_flags = 0;
    pulse_start();
    wait_halt();
    for (int j = 0; j < 4; j++)
      chk(rd_hist[j] == 32'h40 + 32'(4 * j), "R1 fetch address", 64'(rd_hist[j]), 64'(32'h40 + 4 * j));

    // R2: host-owned first descriptor, then poll
    do_reset();
    list_base = 32'h40;
    pulse_start();
    wait_halt();
    repeat (10) @(negedge clk);
    chk(unavail && n_rd == 1 && n_cmd == 0 && n_wr == 0, "R2 stopped and quiet",
        64'({unavail, n_rd[7:0], n_cmd[7:0], n_wr[7:0]}), 64'({1'b1, 8'd1, 8'd0, 8'd0}));
    mem[16] = 32'h80000010; mem[17] = 32'h8; mem[18] = 32'h200; mem[19] = 32'h80;
    poll = 1; @(negedge clk); poll = 0;
    chk(!unavail && rd_en && rd_addr == 32'h40, "R2 resume refetch", 64'({unavail, rd_en, rd_addr}), 64'({2'b01, 32'h40}));
    wait_halt();
    chk(n_cmd == 1 && n_wr == 1 && ca[0] == 32'h200, "R2 resumed descriptor served",
        64'({n_cmd[7:0], n_wr[7:0], ca[0]}), 64'({8'd1, 8'd1, 32'h200}));

    // R8: command held through a stalled ready
    do_reset();
    mem[16] = 32'h80000010; mem[17] = 32'h24; mem[18] = 32'h300; mem[19] = 32'h80;
    list_base = 32'h40; rdy_block = 1;
    pulse_start();
    for (int k = 0; k < 100 && !cmd_valid; k++) @(negedge clk);
    held_a = cmd_addr;
    repeat (6) @(negedge clk);
    chk(cmd_valid && cmd_addr == held_a && cmd_bytes == 13'h24 && n_cmd == 0, "R8 command hold",
        64'({cmd_valid, cmd_bytes, cmd_addr}), 64'({1'b1, 13'h24, held_a}));
    rdy_block = 0;
    wait_halt();
    chk(n_cmd == 1 && ca[0] == 32'h300, "R8 command accepted once", 64'(n_cmd), 1);

    summary();
    $finish;
  end
endmodule